// File: doc/BRIEF.md
# Four-Phase Compute-Stage Handshake Controller

This block sequences one pipeline stage that sits between an upstream producer, a datapath unit and a downstream consumer. All three links use return-to-zero four-phase signalling. For each data item the controller takes a request from upstream, starts the datapath, and waits for the datapath to report completion. It then offers the result downstream and, once the consumer accepts it, acknowledges the producer. After that, all three links return to zero in the same order.

The controller is a clocked state machine. The three environment inputs (upstream request, datapath done, downstream acknowledge) first pass through a reset-cleared synchronizer. The three outputs (datapath start, downstream request, upstream acknowledge) come straight from registers. A sticky error flag records any synchronized input edge that arrives when the protocol does not allow it. The state machine ignores such an edge and keeps waiting for the edge it expects.

Top module: `hs_stage_ctrl`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, `start_o`, `req_dn_o`, `ack_up_o` and `proto_err_o` are all 0 after that edge, and the controller waits for `req_up_i` high.
- R2: In the idle state, `start_o` rises only after `req_up_i` has been seen high.
- R3: `req_dn_o` rises only after `done_i` has been seen high while `start_o` is high.
- R4: `ack_up_o` rises only after `ack_dn_i` has been seen high while `req_dn_o` is high.
- R5: `start_o` falls only after `req_up_i` has been seen low while `ack_up_o` is high.
- R6: `req_dn_o` falls only after `done_i` has been seen low while `start_o` is low.
- R7: `ack_up_o` falls only after `ack_dn_i` has been seen low while `req_dn_o` is low. The controller then returns to idle and accepts the next item.
- R8: At most one of the three outputs changes at any clock edge.
- R9: With the default two synchronizer stages, the output transition that answers an input change appears at the third rising edge after the change.
- R10: `proto_err_o` is set, and stays set until reset, when a synchronized input edge breaks these rules:
  - `req_up_i` may rise only while `start_o` and `ack_up_o` are low, and may fall only while `ack_up_o` is high.
  - `done_i` may rise only while `start_o` is high and `req_dn_o` is low, and may fall only while `start_o` is low and `req_dn_o` is high.
  - `ack_dn_i` may rise only while `req_dn_o` is high and `ack_up_o` is low, and may fall only while `req_dn_o` is low and `ack_up_o` is high.
- R11: An input edge that arrives out of order does not move any output. The controller keeps waiting for the edge it expects.
- R12: Across consecutive items, the six signals step through a twelve-event cycle: rising edges of upstream request, start, done, downstream request, downstream acknowledge and upstream acknowledge, then falling edges in the same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_up_i | input | 1 | Request from the upstream producer (asynchronous) |
| done_i | input | 1 | Completion from the datapath (asynchronous) |
| ack_dn_i | input | 1 | Acknowledge from the downstream consumer (asynchronous) |
| start_o | output | 1 | Launches and, when it falls, resets the datapath |
| req_dn_o | output | 1 | Request to the downstream consumer |
| ack_up_o | output | 1 | Acknowledge to the upstream producer |
| proto_err_o | output | 1 | Sticky out-of-order input flag |

## Verification
Every output change and every error-flag set is due at the third rising edge after the input change that causes it. That is two synchronizer edges plus one state-register edge. The bench drives inputs on falling edges and compares the ports 2 ns after each rising edge, so a mid-cycle input change never lands on a sampling point. The reference model keeps a two-entry queue of sampled inputs and acts on the entry from two edges earlier. This gives it the same latency without copying the register structure. A directed probe counts the edges explicitly for the first start pulse. The random environment adds its own zero-to-four-cycle delays on top of that latency.

// File: rtl/hs_pkg.sv
// Shared definitions for the four-phase stage controller.
// Assumes: the channel indices below are the bit positions used in the
// synchronized input vector by every module of the block.
package hs_pkg;

    localparam int unsigned NUM_CH  = 3;
    localparam int unsigned CH_REQ  = 0;
    localparam int unsigned CH_DONE = 1;
    localparam int unsigned CH_ACK  = 2;

    // Six wait points: one per input edge the controller answers.
    typedef enum logic [2:0] {
        PH_IDLE         = 3'd0,
        PH_WAIT_DONE_HI = 3'd1,
        PH_WAIT_ACK_HI  = 3'd2,
        PH_WAIT_REQ_LO  = 3'd3,
        PH_WAIT_DONE_LO = 3'd4,
        PH_WAIT_ACK_LO  = 3'd5
    } phase_e;

    // Registered outputs of the controller.
    typedef struct packed {
        logic ack_up;
        logic req_dn;
        logic start;
    } hs_drive_t;

endpackage

// File: rtl/hs_sync.sv
// Multi-flop synchronizer for a vector of asynchronous level inputs.
// Assumes: each bit is an independent level that holds for several clocks;
// bits are not sampled coherently with one another. Reset clears every stage.
module hs_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    if (STAGES == 1) begin : g_single
        // Capture the raw inputs in a single stage.
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q <= '0;
            else        stage_q <= d_i;
        end
    end else begin : g_chain
        // Shift the raw inputs through the stage chain.
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q <= '0;
            else        stage_q <= {stage_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/hs_seq.sv
// Sequencer for the twelve-event evaluate / return-to-zero cycle.
// Assumes: inputs are already synchronized. Each phase waits for one input
// level and then toggles exactly one output, so outputs move one per edge.
// Input edges other than the awaited one are ignored here (flagged elsewhere).
module hs_seq
    import hs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_s,
    input  logic      done_s,
    input  logic      ack_s,
    output hs_drive_t drv_o
);

    phase_e    ph_q, ph_d;
    hs_drive_t drv_q, drv_d;

    // Next phase and output: advance only on the awaited input level.
    always_comb begin
        ph_d  = ph_q;
        drv_d = drv_q;
        case (ph_q)
            PH_IDLE:         if (req_s)   begin drv_d.start  = 1'b1; ph_d = PH_WAIT_DONE_HI; end
            PH_WAIT_DONE_HI: if (done_s)  begin drv_d.req_dn = 1'b1; ph_d = PH_WAIT_ACK_HI;  end
            PH_WAIT_ACK_HI:  if (ack_s)   begin drv_d.ack_up = 1'b1; ph_d = PH_WAIT_REQ_LO;  end
            PH_WAIT_REQ_LO:  if (!req_s)  begin drv_d.start  = 1'b0; ph_d = PH_WAIT_DONE_LO; end
            PH_WAIT_DONE_LO: if (!done_s) begin drv_d.req_dn = 1'b0; ph_d = PH_WAIT_ACK_LO;  end
            PH_WAIT_ACK_LO:  if (!ack_s)  begin drv_d.ack_up = 1'b0; ph_d = PH_IDLE;         end
            default: begin
                ph_d  = PH_IDLE;
                drv_d = '0;
            end
        endcase
    end

    // Phase and output registers with synchronous reset to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_IDLE;
            drv_q <= '0;
        end else begin
            ph_q  <= ph_d;
            drv_q <= drv_d;
        end
    end

    assign drv_o = drv_q;

    AST_START_RISE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_q.start) |-> $past(req_s) && !drv_q.ack_up);                     // R2
    AST_REQDN_RISE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_q.req_dn) |-> $past(done_s) && drv_q.start);                     // R3
    AST_ACKUP_RISE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_q.ack_up) |-> $past(ack_s) && drv_q.req_dn);                     // R4
    AST_START_FALL_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drv_q.start) |-> !$past(req_s) && drv_q.ack_up);                     // R5
    AST_REQDN_FALL_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drv_q.req_dn) |-> !$past(done_s) && !drv_q.start);                   // R6
    AST_ACKUP_FALL_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drv_q.ack_up) |-> !$past(ack_s) && !drv_q.req_dn);                   // R7

endmodule

// File: rtl/hs_monitor.sv
// Protocol watchdog for the three synchronized environment inputs.
// Assumes: the outputs seen here are the registered outputs that the
// environment last saw. A legal input edge always arrives while those outputs
// still show the state that invited it. The error flag is sticky until reset.
module hs_monitor
    import hs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] in_s,
    input  hs_drive_t         drv_i,
    output logic              err_o
);

    logic [NUM_CH-1:0] prev_q;
    logic [NUM_CH-1:0] rise, fall, ok_rise, ok_fall;
    logic              violation;
    logic              err_q;

    // Edge detection and legality of each edge against the current outputs.
    always_comb begin
        rise = in_s & ~prev_q;
        fall = ~in_s & prev_q;
        ok_rise[CH_REQ]  = !drv_i.start && !drv_i.ack_up;
        ok_fall[CH_REQ]  = drv_i.ack_up;
        ok_rise[CH_DONE] = drv_i.start && !drv_i.req_dn;
        ok_fall[CH_DONE] = !drv_i.start && drv_i.req_dn;
        ok_rise[CH_ACK]  = drv_i.req_dn && !drv_i.ack_up;
        ok_fall[CH_ACK]  = !drv_i.req_dn && drv_i.ack_up;
        violation = |(rise & ~ok_rise) || |(fall & ~ok_fall);
    end

    // Previous-value register and sticky error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            err_q  <= 1'b0;
        end else begin
            prev_q <= in_s;
            if (violation) err_q <= 1'b1;
        end
    end

    assign err_o = err_q;

    AST_ERR_STAYS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);                                                          // R10
    AST_ERR_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> $past(in_s != prev_q));                                   // R10

endmodule

// File: rtl/hs_stage_ctrl.sv
// Four-phase compute-stage controller: links the upstream channel, the datapath
// start/done pair and the downstream channel in one strict event order.
// Assumes: all three inputs are asynchronous levels, and the environment
// answers each output edge with exactly one input edge.
module hs_stage_ctrl
    import hs_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_up_i,
    input  logic done_i,
    input  logic ack_dn_i,
    output logic start_o,
    output logic req_dn_o,
    output logic ack_up_o,
    output logic proto_err_o
);

    logic [NUM_CH-1:0] raw_in, sync_in;
    hs_drive_t         drv;
    logic [2:0]        drv_bits;

    // Gather the asynchronous inputs in channel order.
    always_comb begin
        raw_in          = '0;
        raw_in[CH_REQ]  = req_up_i;
        raw_in[CH_DONE] = done_i;
        raw_in[CH_ACK]  = ack_dn_i;
    end

    hs_sync #(
        .WIDTH  (NUM_CH),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (sync_in)
    );

    hs_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_s  (sync_in[CH_REQ]),
        .done_s (sync_in[CH_DONE]),
        .ack_s  (sync_in[CH_ACK]),
        .drv_o  (drv)
    );

    hs_monitor u_mon (
        .clk   (clk),
        .rst_n (rst_n),
        .in_s  (sync_in),
        .drv_i (drv),
        .err_o (proto_err_o)
    );

    assign start_o  = drv.start;
    assign req_dn_o = drv.req_dn;
    assign ack_up_o = drv.ack_up;
    assign drv_bits = drv;

    AST_ONE_OUTPUT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(drv_bits ^ $past(drv_bits)) <= 1);                              // R8

endmodule

// File: tb/tb_hs_stage_ctrl.sv
module tb_hs_stage_ctrl;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reqin = 1'b0, done = 1'b0, ackout = 1'b0;
    logic start, reqout, ackin, perr;

    always #5 clk = ~clk;

    hs_stage_ctrl dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_up_i    (reqin),
        .done_i      (done),
        .ack_dn_i    (ackout),
        .start_o     (start),
        .req_dn_o    (reqout),
        .ack_up_o    (ackin),
        .proto_err_o (perr)
    );

    int total = 0;
    int bad   = 0;

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Behavioural reference: queue of sampled inputs, acted on two edges later.
    logic [2:0] hist[$];
    int         mp = 0;
    logic       m_start = 0, m_req = 0, m_ack = 0, m_err = 0;
    logic [2:0] m_prev = 0;
    bit         model_live = 0;

    initial begin
        hist.push_back(3'b0);
        hist.push_back(3'b0);
    end

    always @(posedge clk) begin
        logic [2:0] s;
        if (!rst_n) begin
            hist.delete();
            hist.push_back(3'b0);
            hist.push_back(3'b0);
            mp = 0; m_start = 0; m_req = 0; m_ack = 0; m_err = 0; m_prev = 0;
        end else begin
            s = hist.pop_front();
            hist.push_back({ackout, done, reqin});
            if (s[0] != m_prev[0] && (s[0] ? (m_start || m_ack) : !m_ack)) m_err = 1;
            if (s[1] != m_prev[1] && (s[1] ? (!m_start || m_req) : (m_start || !m_req))) m_err = 1;
            if (s[2] != m_prev[2] && (s[2] ? (!m_req || m_ack) : (m_req || !m_ack))) m_err = 1;
            m_prev = s;
            case (mp)
                0: if (s[0])  begin m_start = 1; mp = 1; end
                1: if (s[1])  begin m_req   = 1; mp = 2; end
                2: if (s[2])  begin m_ack   = 1; mp = 3; end
                3: if (!s[0]) begin m_start = 0; mp = 4; end
                4: if (!s[1]) begin m_req   = 0; mp = 5; end
                5: if (!s[2]) begin m_ack   = 0; mp = 0; end
                default: mp = 0;
            endcase
        end
        model_live = 1;
    end

    // Per-cycle comparison, one-change check and twelve-event order tracking.
    logic [2:0] last_o = 3'b0;
    logic [5:0] last_sig = 6'b0;
    bit         order_on = 0;
    int         ev_pos = 0;
    int         ev_total = 0;

    always @(posedge clk) begin
        logic [5:0] now_sig;
        logic [5:0] diff;
        int         nchg;
        int         bidx;
        #2;
        if (model_live) begin
            chk("R2 R5 R9 start_o vs model",  start,  m_start);
            chk("R3 R6 R9 req_dn_o vs model", reqout, m_req);
            chk("R4 R7 R9 ack_up_o vs model", ackin,  m_ack);
            chk("R10 proto_err_o vs model",   perr,   m_err);
            nchg = $countones({ackin, reqout, start} ^ last_o);
            total++;
            if (nchg > 1) begin
                bad++;
                $display("FAIL R8 outputs changed in one edge: actual=%0d expected<=1", nchg);
            end
            last_o = {ackin, reqout, start};
        end
        now_sig = {ackin, ackout, reqout, done, start, reqin};
        if (order_on) begin
            diff = now_sig ^ last_sig;
            if (diff != 6'b0) begin
                bidx = ev_pos % 6;
                total++;
                if (diff != (6'b1 << bidx) || now_sig[bidx] !== (ev_pos < 6)) begin
                    bad++;
                    $display("FAIL R12 event order: actual change=%b value=%b expected change=%b value=%b",
                             diff, now_sig, 6'b1 << bidx, (ev_pos < 6));
                end
                ev_pos = (ev_pos + 1) % 12;
                ev_total++;
            end
        end
        last_sig = now_sig;
    end

    task automatic wait_out(input int which, input logic v);
        forever begin
            @(negedge clk);
            if ((which == 0 ? start : (which == 1 ? reqout : ackin)) === v) break;
        end
    endtask

    task automatic pause();
        repeat ($urandom_range(0, 4)) @(negedge clk);
    endtask

    task automatic run_item();
        pause(); reqin = 1'b1;
        wait_out(0, 1'b1); pause(); done = 1'b1;
        wait_out(1, 1'b1); pause(); ackout = 1'b1;
        wait_out(2, 1'b1); pause(); reqin = 1'b0;
        wait_out(0, 1'b0); pause(); done = 1'b0;
        wait_out(1, 1'b0); pause(); ackout = 1'b0;
        wait_out(2, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #2;
        chk("R1 start_o after reset",     start,  1'b0);
        chk("R1 req_dn_o after reset",    reqout, 1'b0);
        chk("R1 ack_up_o after reset",    ackin,  1'b0);
        chk("R1 proto_err_o after reset", perr,   1'b0);

        // Latency probe: start answers on the third rising edge.
        @(negedge clk); reqin = 1'b1;
        @(posedge clk); #2; chk("R9 start_o low after edge 1", start, 1'b0);
        @(posedge clk); #2; chk("R9 start_o low after edge 2", start, 1'b0);
        @(posedge clk); #2; chk("R2 R9 start_o high after edge 3", start, 1'b1);

        // Out-of-order acknowledge while waiting for done.
        @(negedge clk); ackout = 1'b1;
        repeat (8) @(posedge clk); #2;
        chk("R11 ack_up_o ignores early ack",  ackin,  1'b0);
        chk("R11 req_dn_o ignores early ack",  reqout, 1'b0);
        chk("R10 proto_err_o on early ack",    perr,   1'b1);
        @(negedge clk); ackout = 1'b0;
        repeat (5) @(posedge clk); #2;
        chk("R10 proto_err_o stays set",       perr,   1'b1);
        chk("R11 start_o still waiting",       start,  1'b1);

        @(negedge clk); rst_n = 1'b0; reqin = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #2;
        chk("R1 proto_err_o cleared by reset", perr,  1'b0);
        chk("R1 start_o cleared by reset",     start, 1'b0);

        // Random-delay environment, fifty items.
        @(negedge clk);
        ev_pos = 0; ev_total = 0; order_on = 1;
        for (int i = 0; i < 50; i++) run_item();
        repeat (6) @(posedge clk); #2;
        order_on = 0;
        total++;
        if (ev_total != 600) begin
            bad++;
            $display("FAIL R12 event count: actual=%0d expected=%0d", ev_total, 600);
        end
        chk("R7 ack_up_o low at end of items", ackin, 1'b0);
        chk("R10 no error on legal traffic",   perr,  1'b0);
        report();
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R12 watchdog expired: actual=hung expected=complete");
        report();
    end

endmodule